// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Sequencer

This block is the clocked core of a processor supervisor. It receives a supply-good flag from an external comparator, an active-low manual-reset request, and a raw activity line from the supervised processor. It combines three reset causes into one reset output: a low supply, a qualified manual request, and a watchdog that has not been serviced. The output stays asserted for a selectable hold time after the last cause clears.

A 4-bit option code selects the hold time and the watchdog timeout. The block captures the code only while reset is asserted. All durations are given in microseconds and converted to clock cycles from a clock-frequency parameter. A second divisor parameter shortens the millisecond-scale periods so that a scaled-down instance can be built. The polarity of the output is fixed by a parameter.

Top module: `supv_reset_seq`

## Requirements
- R1: Reset is asserted while `rst_n` is low. After release it stays asserted until the hold time has passed with no cause present.
- R2: While `supply_ok` is low, reset is asserted from the next clock edge on. After `supply_ok` returns high, reset releases exactly `hold` cycles later, counted from the first edge that samples `supply_ok` high.
- R3: If the supply drops again while reset is being held, the hold count restarts from zero when the supply comes back.
- R4: A low level on `mr_n` counts only after a two-flop synchronizer. Reset asserts once the synchronized input has been low for MR_MIN+MR_DLY consecutive cycles (25 µs plus 12 µs). A shorter low pulse has no effect on the output.
- R5: Reset stays asserted while the qualified manual request is held. After `mr_n` returns high, reset releases `hold` cycles after the synchronized input goes high.
- R6: Every rising edge and every falling edge of the synchronized `wdi` clears the watchdog count. Toggling `wdi` faster than the timeout keeps reset deasserted.
- R7: If `wdi` has no edge for `wdt` cycles after reset releases, reset asserts and is held for one `hold` period.
- R8: `opt[1:0]` selects the hold time: 0 gives 1.4 ms, 1 gives 28 ms, 2 gives 200 ms and 3 gives 1600 ms.
- R9: `opt[3:2]` selects the watchdog timeout: 0 gives 6.2 ms, 1 gives 102 ms, 2 gives 1600 ms and 3 gives 25600 ms.
- R10: `opt` is captured only while reset is asserted. A change made while reset is deasserted does not alter the running watchdog timeout.
- R11: With ACTIVE_LOW=1, `rst_out` is low while reset is asserted. With ACTIVE_LOW=0 it is the exact inverse of that.
- R12: The watchdog count is held at zero while reset is asserted, so no watchdog expiry can occur during reset.
- R13: If `wdi` is fed from `rst_out`, the output repeats with a constant period of about hold plus timeout. The period lies between hold+wdt and hold+wdt+6 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block itself |
| supply_ok | input | 1 | High when the supply is above its threshold; synchronous to clk |
| mr_n | input | 1 | Active-low manual reset request, asynchronous |
| wdi | input | 1 | Watchdog activity line, asynchronous |
| opt | input | 4 | [1:0] hold-time code, [3:2] watchdog-timeout code |
| rst_out | output | 1 | Combined reset, polarity set by ACTIVE_LOW |

## Verification
The assertions assume the following about the inputs:
- `supply_ok` is already synchronous to the clock.
- Every selected duration is at least two cycles, so the hold count has room to restart.

The stimulus meets these assumptions:
- It drives every input on the falling clock edge.
- It uses a scaled clock setting that keeps each hold time at two cycles or more.
- It changes the option code only inside supply dips that last at least three cycles, so the captured code has settled before the hold count runs.

// File: rtl/supv_pkg.sv
package supv_pkg;

   localparam int unsigned OPT_W = 4;

   // hold-time choices in microseconds, indexed by opt[1:0]
   function automatic longint unsigned hold_us(input int unsigned code);
      case (code)
         0:       return 64'd1_400;
         1:       return 64'd28_000;
         2:       return 64'd200_000;
         default: return 64'd1_600_000;
      endcase
   endfunction

   // watchdog timeout choices in microseconds, indexed by opt[3:2]
   function automatic longint unsigned wdt_us(input int unsigned code);
      case (code)
         0:       return 64'd6_200;
         1:       return 64'd102_000;
         2:       return 64'd1_600_000;
         default: return 64'd25_600_000;
      endcase
   endfunction

   // microseconds to clock cycles, never below one cycle
   function automatic longint unsigned us_to_cyc(input longint unsigned us,
                                                 input longint unsigned hz,
                                                 input longint unsigned div);
      longint unsigned c;
      c = (us * hz) / (64'd1_000_000 * div);
      return (c == 0) ? 64'd1 : c;
   endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
   parameter int unsigned W       = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         logic st1, st2;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st1 <= RST_VAL[i];
               st2 <= RST_VAL[i];
            end else begin
               st1 <= d[i];
               st2 <= st1;
            end
         end
         assign q[i] = st2;
      end
   endgenerate
endmodule

// File: rtl/supv_mr_qual.sv
module supv_mr_qual #(
   parameter int unsigned LIM = 7,
   parameter int unsigned CW  = $clog2(LIM + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic low_s,
   output logic active
);
   generate
      if (LIM < 2) begin : g_bad_lim
         $error("supv_mr_qual: LIM must be at least 2");
      end
   endgenerate

   localparam logic [CW-1:0] LIM_V = CW'(LIM);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!low_s)         cnt <= '0;
      else if (cnt != LIM_V)   cnt <= cnt + CW'(1);
   end

   assign active = low_s && (cnt == LIM_V);

   AST_MR_NEEDS_LOW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> ($past(low_s) && $past(low_s, 2))); // R4
endmodule

// File: rtl/supv_wdog.sv
module supv_wdog #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wdi_s,
   input  logic          hold,
   input  logic [CW-1:0] lim,
   output logic          expire
);
   logic          prev;
   logic          edge_s;
   logic [CW-1:0] cnt;

   assign edge_s = wdi_s ^ prev;
   assign expire = !hold && !edge_s && (cnt == lim - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= 1'b0;
         cnt  <= '0;
      end else begin
         prev <= wdi_s;
         if (hold || edge_s || expire) cnt <= '0;
         else                          cnt <= cnt + CW'(1);
      end
   end

   AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      edge_s |=> (cnt == '0)); // R6
   AST_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (cnt == '0)); // R12
endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq #(
   parameter longint unsigned CLK_HZ     = 50_000_000,
   parameter int unsigned     TIME_DIV   = 1,
   parameter bit              ACTIVE_LOW = 1'b1,
   parameter int unsigned     MR_MIN_US  = 25,
   parameter int unsigned     MR_DLY_US  = 12
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         supply_ok,
   input  logic                         mr_n,
   input  logic                         wdi,
   input  logic [supv_pkg::OPT_W-1:0]   opt,
   output logic                         rst_out
);
   import supv_pkg::*;

   localparam longint unsigned HOLD_MAX = us_to_cyc(hold_us(3), CLK_HZ, 64'(TIME_DIV));
   localparam longint unsigned WDT_MAX  = us_to_cyc(wdt_us(3), CLK_HZ, 64'(TIME_DIV));
   localparam int unsigned HCW = $clog2(HOLD_MAX + 1);
   localparam int unsigned WCW = $clog2(WDT_MAX + 1);
   localparam int unsigned MR_LIM = int'(us_to_cyc(64'(MR_MIN_US), CLK_HZ, 64'd1)
                                       + us_to_cyc(64'(MR_DLY_US), CLK_HZ, 64'd1));

   generate
      if (CLK_HZ == 0) begin : g_bad_clk
         $error("supv_reset_seq: CLK_HZ must be nonzero");
      end
      if (TIME_DIV == 0) begin : g_bad_div
         $error("supv_reset_seq: TIME_DIV must be nonzero");
      end
   endgenerate

   // cycle tables, one entry per option code
   logic [HCW-1:0] hold_tbl [4];
   logic [WCW-1:0] wdt_tbl  [4];
   generate
      for (genvar i = 0; i < 4; i++) begin : g_tbl
         assign hold_tbl[i] = HCW'(us_to_cyc(hold_us(i), CLK_HZ, 64'(TIME_DIV)));
         assign wdt_tbl[i]  = WCW'(us_to_cyc(wdt_us(i),  CLK_HZ, 64'(TIME_DIV)));
      end
   endgenerate

   logic [1:0]             async_s;
   logic                   mr_act;
   logic                   wd_exp;
   logic                   rst_active;
   logic [OPT_W-1:0]       opt_q;
   logic [HCW-1:0]         hcnt;
   logic [HCW-1:0]         hold_lim;
   logic                   cause;

   supv_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({wdi, mr_n}),
      .q     (async_s)
   );

   supv_mr_qual #(.LIM(MR_LIM)) u_mr (
      .clk    (clk),
      .rst_n  (rst_n),
      .low_s  (~async_s[0]),
      .active (mr_act)
   );

   supv_wdog #(.CW(WCW)) u_wd (
      .clk    (clk),
      .rst_n  (rst_n),
      .wdi_s  (async_s[1]),
      .hold   (rst_active),
      .lim    (wdt_tbl[opt_q[3:2]]),
      .expire (wd_exp)
   );

   // option code follows the input only while reset is asserted
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          opt_q <= '0;
      else if (rst_active) opt_q <= opt;
   end

   assign hold_lim = hold_tbl[opt_q[1:0]];
   assign cause    = !supply_ok || mr_act || wd_exp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_active <= 1'b1;
         hcnt       <= '0;
      end else if (cause) begin
         rst_active <= 1'b1;
         hcnt       <= '0;
      end else if (rst_active) begin
         if (hcnt >= hold_lim - HCW'(1)) rst_active <= 1'b0;
         else                            hcnt <= hcnt + HCW'(1);
      end
   end

   generate
      if (ACTIVE_LOW) begin : g_out_low
         assign rst_out = ~rst_active;
      end else begin : g_out_high
         assign rst_out = rst_active;
      end
   endgenerate

   AST_SUPPLY_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> rst_active); // R2
   AST_HOLD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_active && !supply_ok) |=> (hcnt == '0)); // R3
   AST_MR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      mr_act |=> rst_active); // R5
   AST_OPT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_active |=> $stable(opt_q)); // R10
   AST_NO_WD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      rst_active |-> !wd_exp); // R12
endmodule

// File: tb/supv_reset_seq_test.sv
`timescale 1ns/1ps
module supv_reset_seq_test;
   localparam longint unsigned CLK = 200_000;
   localparam int unsigned     DIV = 100;
   localparam int MR_TOT = 5 + 2;   // 25 us and 12 us at CLK

   logic clk = 1'b0;
   logic rst_n, supply_ok, mr_n, wdi_reg, kick, loop_en;
   logic [3:0] opt;
   logic rst_lo, rst_hi, wdi;
   int tests = 0, fails = 0, pol_err = 0;

   always #10 clk = ~clk;   // 50 MHz

   assign wdi = loop_en ? rst_lo : wdi_reg;

   supv_reset_seq #(.CLK_HZ(CLK), .TIME_DIV(DIV), .ACTIVE_LOW(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mr_n(mr_n),
      .wdi(wdi), .opt(opt), .rst_out(rst_lo));
   supv_reset_seq #(.CLK_HZ(CLK), .TIME_DIV(DIV), .ACTIVE_LOW(1'b0)) uut_hi (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mr_n(mr_n),
      .wdi(wdi), .opt(opt), .rst_out(rst_hi));

   function automatic int cyc(input longint unsigned us);
      longint unsigned c = (us * CLK) / (64'd1_000_000 * DIV);
      return (c == 0) ? 1 : int'(c);
   endfunction
   function automatic int hold_c(input int code);
      case (code) 0: return cyc(1400); 1: return cyc(28000);
                  2: return cyc(200000); default: return cyc(1600000); endcase
   endfunction
   function automatic int wdt_c(input int code);
      case (code) 0: return cyc(6200); 1: return cyc(102000);
                  2: return cyc(1600000); default: return cyc(25600000); endcase
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick; @(posedge clk); #1; endtask
   function automatic bit asserted; return rst_lo == 1'b0; endfunction

   task automatic wait_release(output int n);
      n = 0;
      do begin tick(); n++; end while (asserted() && n < 100000);
   endtask
   task automatic wait_assert(output int n);
      n = 0;
      do begin tick(); n++; end while (!asserted() && n < 100000);
   endtask

   // supply dip that also loads a new option code
   task automatic dip(input logic [1:0] wc, input logic [1:0] hc, input int len);
      @(negedge clk); supply_ok = 1'b0; opt = {wc, hc};
      repeat (len) tick();
   endtask

   // watchdog kicker: toggles every 6 cycles, both edges matter
   initial begin
      int k = 0;
      forever begin
         @(negedge clk);
         if (kick) begin k++; if (k >= 6) begin k = 0; wdi_reg = ~wdi_reg; end end
      end
   end

   always @(negedge clk) if (rst_n && (rst_hi !== ~rst_lo)) pol_err++;

   initial begin
      repeat (190000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int n, p1, p2, bad;
      void'($urandom(32'd4711));
      rst_n = 0; supply_ok = 0; mr_n = 1; wdi_reg = 0; kick = 0; loop_en = 0;
      opt = {2'd1, 2'd0};
      repeat (5) tick();
      chk("R1 reset state low", rst_lo, 0);
      chk("R11 inverse output", rst_hi, 1);
      @(negedge clk); rst_n = 1;
      repeat (3) tick();
      chk("R2 supply low holds", asserted(), 1);
      @(negedge clk); supply_ok = 1; kick = 1;
      wait_release(n);
      chk("R1 power-up hold", n, hold_c(0));

      for (int c = 1; c < 4; c++) begin
         dip(2'd1, 2'(c), 4);
         chk("R2 dip asserts", asserted(), 1);
         @(negedge clk); supply_ok = 1;
         wait_release(n);
         chk("R8 hold code", n, hold_c(c));
      end

      // R3: dip in the middle of the hold
      dip(2'd1, 2'd1, 4);
      @(negedge clk); supply_ok = 1;
      repeat (30) tick();
      chk("R3 still held", asserted(), 1);
      @(negedge clk); supply_ok = 0;
      tick(); tick();
      @(negedge clk); supply_ok = 1;
      wait_release(n);
      chk("R3 hold restarted", n, hold_c(1));

      // R6: steady kicking, short timeout
      dip(2'd0, 2'd0, 4);
      @(negedge clk); supply_ok = 1;
      wait_release(n);
      bad = 0;
      for (int i = 0; i < 300; i++) begin tick(); if (asserted()) bad++; end
      chk("R6 kicked no reset", bad, 0);

      // R7, R10: timeout with code changed after release
      kick = 0;
      dip(2'd0, 2'd1, 4);
      @(negedge clk); supply_ok = 1;
      wait_release(n);
      chk("R8 hold 28ms", n, hold_c(1));
      @(negedge clk); opt = {2'd1, 2'd1};
      wait_assert(n);
      chk("R10 ignored change / R7 timeout", n, wdt_c(0));
      wait_release(n);
      chk("R7 timeout hold", n, hold_c(1));
      kick = 1;

      // R9: each slower timeout code
      for (int c = 1; c < 4; c++) begin
         kick = 0;
         dip(2'(c), 2'd0, 4);
         @(negedge clk); supply_ok = 1;
         wait_release(n);
         wait_assert(n);
         chk("R9 timeout code", n, wdt_c(c));
         kick = 1;
         wait_release(n);
      end

      // R4, R5: manual reset
      dip(2'd1, 2'd1, 4);
      @(negedge clk); supply_ok = 1;
      wait_release(n);
      @(negedge clk); mr_n = 0;
      repeat (MR_TOT - 1) @(negedge clk);
      mr_n = 1;
      bad = 0;
      for (int i = 0; i < 20; i++) begin tick(); if (asserted()) bad++; end
      chk("R4 short pulse ignored", bad, 0);
      @(negedge clk); mr_n = 0;
      wait_assert(n);
      chk("R4 qualified delay", n, MR_TOT + 3);
      bad = 0;
      for (int i = 0; i < 50; i++) begin tick(); if (!asserted()) bad++; end
      chk("R5 held while low", bad, 0);
      @(negedge clk); mr_n = 1;
      wait_release(n);
      chk("R5 release after hold", n, hold_c(1) + 2);

      // R2, R3 random dips
      for (int it = 0; it < 20; it++) begin
         int hc = int'($urandom % 2);
         repeat (5 + ($urandom % 16)) tick();
         dip(2'd1, 2'(hc), 3 + int'($urandom % 6));
         chk("R2 random dip asserted", asserted(), 1);
         @(negedge clk); supply_ok = 1;
         wait_release(n);
         chk("R3 random hold", n, hold_c(hc));
      end

      // R13 loopback
      kick = 0;
      dip(2'd0, 2'd0, 4);
      @(negedge clk); supply_ok = 1; loop_en = 1;
      wait_release(n);
      wait_assert(n);
      wait_release(n); p1 = n; wait_assert(n); p1 += n;
      wait_release(n); p2 = n; wait_assert(n); p2 += n;
      chk("R13 period in range",
          (p1 >= hold_c(0) + wdt_c(0) && p1 <= hold_c(0) + wdt_c(0) + 6), 1);
      chk("R13 period constant", p2, p1);

      chk("R11 polarity pair", pol_err, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule